// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART's serial pins and an infrared transceiver. On the transmit side it turns each zero bit of the UART output into one short positive light pulse. A one bit leaves the optical output dark for the whole bit. On the receive side it turns each pulse caught by the photodiode back into a UART-level zero that lasts one full bit period, so an ordinary 16x-oversampling receiver can read it.

Two pulse-width modes exist. In normal mode the pulse covers three of the sixteen oversampling ticks of the bit, starting at tick 7. In low-power mode the pulse has a fixed length taken from a separate divided clock. An 8-bit divisor field sets the divide ratio of the reference clock anywhere from 1 to 256, and the pulse lasts three periods of that divided clock. A select input can bypass the codec so that the pins carry plain UART levels. The link is half-duplex: while the local transmitter is busy, the receive path ignores the photodiode, so the port's own light is not echoed back into its receiver. The 16x tick comes from the UART's baud generator as a one-cycle enable.

Top module: `sir_codec`

## Requirements
- R1: After reset, with the codec selected, `ir_txd` is 0 and `uart_rxd` is 1.
- R2: In normal mode (`sir_en`=1, `low_power`=0), a zero bit makes `ir_txd` high for exactly 3 tick periods. It rises one clock after the clock edge that samples tick number 7 of the bit, counting the bit's first tick as 0.
- R3: With the codec selected, a one bit keeps `ir_txd` low for the entire bit.
- R4: In low-power mode (`sir_en`=1, `low_power`=1), a zero bit makes `ir_txd` high for exactly 3*(`lp_div`+1) clock cycles. An `lp_div` value v therefore selects a divide ratio of v+1, from 1 to 256.
- R5: In low-power mode the pulse rises in the same clock as a normal-mode pulse would.
- R6: Bit boundaries follow `uart_txd`. Every level change restarts the 16-tick bit count, and a run of equal bits advances one bit every 16 ticks.
- R7: With the codec selected, a rising edge on `ir_rxd` drives `uart_rxd` low 3 clocks after the edge. `uart_rxd` stays low until one clock after the 16th tick that follows detection. The width of the incoming pulse plays no part.
- R8: A rising edge on `ir_rxd` that is detected while `tx_active` is 1 leaves `uart_rxd` high.
- R9: With `sir_en`=0, `ir_txd` follows `uart_txd` one clock late. `uart_rxd` follows `ir_rxd` three clocks late, through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| tick16 | input | 1 | One-cycle enable at 16 times the baud rate |
| sir_en | input | 1 | 1 selects the infrared codec, 0 selects plain pass-through |
| low_power | input | 1 | 1 selects the fixed-width low-power pulse |
| lp_div | input | DIV_W | Low-power divisor; the ratio is the value plus one |
| tx_active | input | 1 | Local transmitter busy; blocks receive detection |
| uart_txd | input | 1 | Serial data from the UART transmitter |
| ir_txd | output | 1 | Drive to the infrared LED, active high |
| ir_rxd | input | 1 | Pulse from the infrared detector, active high, asynchronous |
| uart_rxd | output | 1 | Serial level to the UART receiver |

## Verification
The bench sends every byte value as a complete frame. Consecutive zero bits that have no edge between them test how the bit count stays aligned. A codec that lost that alignment would move or merge pulses in bytes with runs of zeros.

Low-power widths are swept across small divisors and also at the 256 end. An off-by-one in the divider would show up as a width error of three clocks per step.

The receive stretch is timed to the exact clock for both long and very short input pulses. A design that echoed its own transmission would pull `uart_rxd` low while `tx_active` is high, and the bench watches for that. Pass-through latency is checked in both directions.

// File: rtl/sir_pkg.sv
package sir_pkg;

  typedef enum logic [1:0] {
    MODE_PASS   = 2'd0,
    MODE_NORMAL = 2'd1,
    MODE_LOWPWR = 2'd2
  } sir_mode_e;

  function automatic sir_mode_e pick_mode(input logic codec_on, input logic lp_on);
    if (!codec_on)  return MODE_PASS;
    else if (lp_on) return MODE_LOWPWR;
    else            return MODE_NORMAL;
  endfunction

endpackage

// File: rtl/sir_tx_phase.sv
module sir_tx_phase #(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_START = 7,
  parameter int PULSE_TICKS = 3,
  localparam int PW = $clog2(OVERSAMPLE)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          txd,
  output logic [PW-1:0] phase,
  output logic          norm_pulse,
  output logic          lp_start
);

  localparam logic [PW-1:0] LAST_PH  = PW'(OVERSAMPLE - 1);
  localparam logic [PW-1:0] FIRST_ON = PW'(PULSE_START);
  localparam logic [PW-1:0] LAST_ON  = PW'(PULSE_START + PULSE_TICKS - 1);

  logic [PW-1:0] phase_q, phase_d;
  logic          last_q;
  logic          pulse_q;

  // A level change marks tick 0 of a new bit; otherwise count and wrap.
  always_comb begin
    if (txd != last_q)        phase_d = '0;
    else if (phase_q == LAST_PH) phase_d = '0;
    else                      phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      last_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else if (tick) begin
      phase_q <= phase_d;
      last_q  <= txd;
      pulse_q <= !txd && (phase_d >= FIRST_ON) && (phase_d <= LAST_ON);
    end
  end

  assign phase      = phase_q;
  assign norm_pulse = pulse_q;
  assign lp_start   = tick && !txd && (phase_d == FIRST_ON);

endmodule

// File: rtl/sir_lp_timer.sv
module sir_lp_timer #(
  parameter int DIV_W   = 8,
  parameter int PERIODS = 3,
  localparam int CW = $clog2(PERIODS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [DIV_W-1:0] div,
  output logic             active,
  output logic [CW-1:0]    period_cnt
);

  localparam logic [CW-1:0] LAST_PER = CW'(PERIODS - 1);

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] pre_q;
  logic [CW-1:0]    cnt_q;
  logic             act_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q <= '0;
      pre_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b0;
    end else if (start) begin
      // Divisor is captured so a mid-pulse write cannot bend the width.
      div_q <= div;
      pre_q <= '0;
      cnt_q <= '0;
      act_q <= 1'b1;
    end else if (act_q) begin
      if (pre_q == div_q) begin
        pre_q <= '0;
        if (cnt_q == LAST_PER) begin
          act_q <= 1'b0;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  assign active     = act_q;
  assign period_cnt = cnt_q;

endmodule

// File: rtl/sir_rx_stretch.sv
module sir_rx_stretch #(
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SCW = $clog2(OVERSAMPLE + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick,
  input  logic           enable,
  input  logic           block,
  input  logic           ir_in,
  output logic           synced,
  output logic           level,
  output logic [SCW-1:0] cnt
);

  localparam logic [SCW-1:0] FULL = SCW'(OVERSAMPLE);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic [SCW-1:0]         cnt_q;
  logic                   rise;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) sync_q[0] <= 1'b0;
        else     sync_q[0] <= ir_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) sync_q[g] <= 1'b0;
        else     sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign synced = sync_q[SYNC_STAGES-1];
  assign rise   = synced && !prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      prev_q <= synced;
      if (rise && enable && !block)  cnt_q <= FULL;
      else if (tick && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign level = (cnt_q == '0);
  assign cnt   = cnt_q;

endmodule

// File: rtl/sir_codec.sv
module sir_codec
  import sir_pkg::*;
#(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_START = 7,
  parameter int PULSE_TICKS = 3,
  parameter int LP_PERIODS  = 3,
  parameter int DIV_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int PW  = $clog2(OVERSAMPLE),
  localparam int CW  = $clog2(LP_PERIODS + 1),
  localparam int SCW = $clog2(OVERSAMPLE + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick16,
  input  logic             sir_en,
  input  logic             low_power,
  input  logic [DIV_W-1:0] lp_div,
  input  logic             tx_active,
  input  logic             uart_txd,
  output logic             ir_txd,
  input  logic             ir_rxd,
  output logic             uart_rxd
);

  sir_mode_e      mode;
  logic [PW-1:0]  tx_phase;
  logic           norm_pulse;
  logic           lp_kick;
  logic           lp_active;
  logic [CW-1:0]  lp_cnt;
  logic           rx_sync;
  logic           rx_level;
  logic [SCW-1:0] stretch_cnt;
  logic           ir_txd_q;
  logic           uart_rxd_q;

  assign mode = pick_mode(sir_en, low_power);

  sir_tx_phase #(
    .OVERSAMPLE (OVERSAMPLE),
    .PULSE_START(PULSE_START),
    .PULSE_TICKS(PULSE_TICKS)
  ) u_phase (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick16),
    .txd       (uart_txd),
    .phase     (tx_phase),
    .norm_pulse(norm_pulse),
    .lp_start  (lp_kick)
  );

  sir_lp_timer #(
    .DIV_W  (DIV_W),
    .PERIODS(LP_PERIODS)
  ) u_lp (
    .clk       (clk),
    .rst       (rst),
    .start     (lp_kick && mode == MODE_LOWPWR),
    .div       (lp_div),
    .active    (lp_active),
    .period_cnt(lp_cnt)
  );

  sir_rx_stretch #(
    .OVERSAMPLE (OVERSAMPLE),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_rx (
    .clk   (clk),
    .rst   (rst),
    .tick  (tick16),
    .enable(sir_en),
    .block (tx_active),
    .ir_in (ir_rxd),
    .synced(rx_sync),
    .level (rx_level),
    .cnt   (stretch_cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_txd_q   <= 1'b0;
      uart_rxd_q <= 1'b1;
    end else begin
      case (mode)
        MODE_PASS: begin
          ir_txd_q   <= uart_txd;
          uart_rxd_q <= rx_sync;
        end
        MODE_NORMAL: begin
          ir_txd_q   <= norm_pulse;
          uart_rxd_q <= rx_level;
        end
        default: begin
          ir_txd_q   <= lp_active;
          uart_rxd_q <= rx_level;
        end
      endcase
    end
  end

  assign ir_txd   = ir_txd_q;
  assign uart_rxd = uart_rxd_q;

endmodule

// File: rtl/sir_codec_chk.sv
module sir_codec_chk #(
  parameter int OVERSAMPLE  = 16,
  parameter int PULSE_START = 7,
  parameter int PULSE_TICKS = 3,
  parameter int LP_PERIODS  = 3,
  localparam int PW  = $clog2(OVERSAMPLE),
  localparam int CW  = $clog2(LP_PERIODS + 1),
  localparam int SCW = $clog2(OVERSAMPLE + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           sir_en,
  input logic           tx_active,
  input logic           uart_txd,
  input logic           ir_txd,
  input logic [PW-1:0]  tx_phase,
  input logic           norm_pulse,
  input logic [CW-1:0]  lp_cnt,
  input logic [SCW-1:0] stretch_cnt
);

  localparam logic [PW-1:0]  FIRST_ON = PW'(PULSE_START);
  localparam logic [PW-1:0]  LAST_ON  = PW'(PULSE_START + PULSE_TICKS - 1);
  localparam logic [CW-1:0]  LAST_PER = CW'(LP_PERIODS - 1);
  localparam logic [SCW-1:0] FULL     = SCW'(OVERSAMPLE);

  // R2: the normal pulse only lives inside its tick window
  p_pulse_window_r2: assert property (@(posedge clk) disable iff (rst)
    norm_pulse |-> (tx_phase >= FIRST_ON && tx_phase <= LAST_ON));

  // R4: low-power period counter never passes its last period
  p_lp_period_bound_r4: assert property (@(posedge clk) disable iff (rst)
    lp_cnt <= LAST_PER);

  // R7: stretch never exceeds one bit of ticks
  p_stretch_bound_r7: assert property (@(posedge clk) disable iff (rst)
    stretch_cnt <= FULL);

  // R8: an idle stretch stays idle across a busy transmit cycle
  p_no_echo_r8: assert property (@(posedge clk) disable iff (rst)
    (stretch_cnt == '0 && tx_active) |=> stretch_cnt == '0);

  // R9: bypass copies the UART level one clock late
  p_bypass_tx_r9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(sir_en)) |-> ir_txd == $past(uart_txd));

endmodule

bind sir_codec sir_codec_chk #(
  .OVERSAMPLE (OVERSAMPLE),
  .PULSE_START(PULSE_START),
  .PULSE_TICKS(PULSE_TICKS),
  .LP_PERIODS (LP_PERIODS)
) chk_i (
  .clk        (clk),
  .rst        (rst),
  .sir_en     (sir_en),
  .tx_active  (tx_active),
  .uart_txd   (uart_txd),
  .ir_txd     (ir_txd),
  .tx_phase   (tx_phase),
  .norm_pulse (norm_pulse),
  .lp_cnt     (lp_cnt),
  .stretch_cnt(stretch_cnt)
);

// File: tb/sir_codec_tb_top.sv
module sir_codec_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst;
  logic       tick16;
  logic       sir_en;
  logic       low_power;
  logic [7:0] lp_div;
  logic       tx_active;
  logic       uart_txd;
  logic       ir_txd;
  logic       ir_rxd;
  logic       uart_rxd;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;
  int per   = 4;

  int hi_tx, first_tx, lo_rx, first_lo, hi_rx, first_rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  sir_codec dut_i (
    .clk      (clk),
    .rst      (rst),
    .tick16   (tick16),
    .sir_en   (sir_en),
    .low_power(low_power),
    .lp_div   (lp_div),
    .tx_active(tx_active),
    .uart_txd (uart_txd),
    .ir_txd   (ir_txd),
    .ir_rxd   (ir_rxd),
    .uart_rxd (uart_rxd)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Plays a number of bit slots; ir_rxd is held high for the first pl clocks.
  task automatic play(input int slots, input int pl);
    int idx = 0;
    hi_tx = 0; first_tx = -1; lo_rx = 0; first_lo = -1; hi_rx = 0; first_rx = -1;
    for (int s = 0; s < slots; s++) begin
      for (int c = 0; c < per; c++) begin
        tick16 = (c == 0);
        ir_rxd = (idx < pl);
        @(negedge clk);
        idx++;
        if (ir_txd) begin
          hi_tx++;
          if (first_tx < 0) first_tx = idx;
        end
        if (!uart_rxd) begin
          lo_rx++;
          if (first_lo < 0) first_lo = idx;
        end else begin
          hi_rx++;
          if (first_rx < 0) first_rx = idx;
        end
      end
    end
    tick16 = 1'b0;
    ir_rxd = 1'b0;
  endtask

  task automatic send_bit(input logic b, input string req_hi, input int exp_hi);
    uart_txd = b;
    play(16, 0);
    check(hi_tx == exp_hi, req_hi, "pulse width", hi_tx, exp_hi);
    if (exp_hi > 0)
      check(first_tx == 7*per + 2, "R5/R2", "pulse start", first_tx, 7*per + 2);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", WATCHDOG, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; tick16 = 1'b0; sir_en = 1'b1; low_power = 1'b0; lp_div = '0;
    tx_active = 1'b0; uart_txd = 1'b1; ir_rxd = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(ir_txd == 1'b0, "R1", "ir_txd after reset", ir_txd, 0);
    check(uart_rxd == 1'b1, "R1", "uart_rxd after reset", uart_rxd, 1);

    // R2 R3 R6: every byte as a full frame in normal mode
    per = 2;
    for (int v = 0; v < 256; v++) begin
      send_bit(1'b0, "R2", 3*per);
      for (int b = 0; b < 8; b++) begin
        if (v[b]) send_bit(1'b1, "R3", 0);
        else      send_bit(1'b0, "R6", 3*per);
      end
      send_bit(1'b1, "R3", 0);
    end

    // R4 R5: low-power width across small divisors
    low_power = 1'b1;
    per = 8;
    for (int d = 0; d <= 20; d++) begin
      lp_div = 8'(d);
      send_bit(1'b0, "R4", 3*(d+1));
      send_bit(1'b1, "R3", 0);
    end
    // R4: largest ratio, 256
    per = 100;
    lp_div = 8'd255;
    send_bit(1'b0, "R4", 768);
    send_bit(1'b1, "R3", 0);

    // R7: receive stretch, long pulse in normal mode
    low_power = 1'b0;
    for (int p = 4; p <= 6; p++) begin
      per = p;
      play(20, 3*per);
      check(lo_rx == 16*per - 2, "R7", "stretch length", lo_rx, 16*per - 2);
      check(first_lo == 4, "R7", "stretch start", first_lo, 4);
    end
    // R7: two-clock pulse in low-power mode still gives a full bit
    low_power = 1'b1;
    per = 4;
    play(20, 2);
    check(lo_rx == 16*per - 2, "R7", "short pulse stretch", lo_rx, 16*per - 2);
    low_power = 1'b0;

    // R8: pulse while transmitting is ignored
    tx_active = 1'b1;
    play(20, 3*per);
    check(lo_rx == 0, "R8", "echo while busy", lo_rx, 0);
    tx_active = 1'b0;
    play(20, 3*per);
    check(lo_rx == 16*per - 2, "R8", "receive after busy", lo_rx, 16*per - 2);

    // R9: bypass
    sir_en = 1'b0;
    uart_txd = 1'b0;
    play(2, 0);
    check(hi_tx == 0, "R9", "bypass low", hi_tx, 0);
    uart_txd = 1'b1;
    play(2, 0);
    check(hi_tx == 2*per, "R9", "bypass high", hi_tx, 2*per);
    check(first_tx == 1, "R9", "bypass tx latency", first_tx, 1);
    play(3, 5);
    check(hi_rx == 5, "R9", "bypass rx width", hi_rx, 5);
    check(first_rx == 3, "R9", "bypass rx latency", first_rx, 3);
    sir_en = 1'b1;
    @(negedge clk);
    check(uart_rxd == 1'b1, "R9", "codec rx idle after bypass", uart_rxd, 1);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule